// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory command into a stream of element addresses, one per cycle, for the load/store pipeline of a vector unit. A command carries an access mode, a scalar base address, a scalar stride or multiplier, and the current vector length. In the three address modes the block emits byte addresses. In unit-stride mode consecutive 8-byte words are addressed. In constant-stride mode the scalar stride sets the step between elements. In indexed mode, used for gather and scatter, each element's offset arrives from an index stream that the vector register file supplies.

A fourth mode emits no addresses. It produces the values 0, m, 2m, … for a scalar m, so that the register file can store an index vector for a later indexed access. Every output element carries its element number. A valid/ready handshake lets the memory side stall the stream. A single-cycle done pulse marks the end of each command, including a command of length zero.

The vector length is clamped to the largest supported length, which is 64 by default. A start request that arrives while a command is running is ignored.

Top module: `vec_addr_gen`

## Requirements
- R1: In unit-stride mode (mode code 0), element e has address (base with its low 3 bits cleared) + 8·e.
- R2: In constant-stride mode (mode code 1), element e has address (base with low 3 bits cleared) + e·(stride with low 3 bits cleared), modulo 2^AW.
- R3: In indexed mode (mode code 2), element e has address (base with low 3 bits cleared) + (index e with low 3 bits cleared). An index is consumed (idx_ready_o and idx_valid_i both high) only in a cycle where element e is handed over, and no element is offered while idx_valid_i is low.
- R4: In index-generation mode (mode code 3), element e carries the value e·stride_i modulo 2^AW. The low bits are not cleared, and the base is ignored.
- R5: In the three address modes, every address offered has its low 3 bits equal to zero, whatever the low bits of base, stride or index.
- R6: Elements are offered in order 0, 1, 2, … with no gap or repeat under any pattern of out_ready_i. While out_valid_o is high and out_ready_i is low, the address and element number hold.
- R7: The number of elements handed over equals vlen_i when vlen_i ≤ 64, and equals 64 when vlen_i > 64.
- R8: A start with vlen_i = 0 offers no element and raises done_o for exactly the cycle after the start is taken.
- R9: done_o is high for exactly the one cycle after the final handshake, and busy_o is low in that cycle.
- R10: start_i is ignored while busy_o is high. The running command's addresses and element count are unaffected.
- R11: After reset, busy_o, out_valid_o, idx_ready_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a command (taken when not busy) |
| mode_i | input | 2 | 0 unit-stride, 1 constant-stride, 2 indexed, 3 index generation |
| base_i | input | AW (32) | Scalar base byte address |
| stride_i | input | AW (32) | Byte stride (mode 1) or multiplier (mode 3) |
| vlen_i | input | LW (8) | Requested vector length |
| idx_valid_i | input | 1 | Index stream element present |
| idx_data_i | input | AW (32) | Byte offset of the current index element |
| idx_ready_o | output | 1 | Index element consumed this cycle when valid |
| busy_o | output | 1 | Command in progress |
| out_valid_o | output | 1 | Element address offered |
| out_ready_i | input | 1 | Downstream accepts the offered element |
| out_addr_o | output | AW (32) | Element address or generated index value |
| out_elem_o | output | 6 | Element number |
| done_o | output | 1 | One-cycle command-complete pulse |

## Verification
The hold checks assume two things about the inputs. In indexed mode, the index stream keeps idx_valid_i and idx_data_i steady while an element is offered but not accepted. The command inputs are assumed to matter only in the cycle a start is taken. The bench holds the index stream low only before the first element of an indexed command. After that it changes idx_data_i only after a handshake, so the index under an offered element never moves. The downstream ready toggles freely, from a per-command pattern.

// File: rtl/vag_pkg.sv
package vag_pkg;
   typedef enum logic [1:0] {
      VAG_UNIT   = 2'd0,
      VAG_STRIDE = 2'd1,
      VAG_INDEX  = 2'd2,
      VAG_IOTA   = 2'd3
   } vag_mode_e;

   function automatic logic is_addr_mode(input vag_mode_e m);
      return m != VAG_IOTA;
   endfunction
endpackage

// File: rtl/vag_len_clamp.sv
module vag_len_clamp #(
   parameter int LW    = 8,
   parameter int MAXVL = 64,
   localparam int CW   = $clog2(MAXVL + 1)
) (
   input  logic [LW-1:0] req_i,
   output logic [CW-1:0] eff_o
);
   generate
      if (MAXVL < 1) begin : g_bad_max
         $error("vag_len_clamp: MAXVL must be positive");
      end
      if ((1 << LW) - 1 <= MAXVL) begin : g_no_clamp
         assign eff_o = CW'(req_i);
      end else begin : g_clamp
         assign eff_o = (req_i > LW'(MAXVL)) ? CW'(MAXVL) : CW'(req_i);
      end
   endgenerate

   always_comb begin
      a_r7_clamp_bound: assert (eff_o <= CW'(MAXVL));
   end
endmodule

// File: rtl/vag_elem_ctr.sv
module vag_elem_ctr #(
   parameter int MAXVL = 64,
   localparam int CW   = $clog2(MAXVL + 1),
   localparam int EW   = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_i,
   input  logic [CW-1:0] len_i,
   output logic [EW-1:0] elem_o,
   output logic          last_o
);
   logic [EW-1:0] elem_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       elem_q <= '0;
      else if (load_i)  elem_q <= '0;
      else if (step_i)  elem_q <= elem_q + 1'b1;
   end

   assign elem_o = elem_q;
   assign last_o = ({1'b0, elem_q} == (len_i - 1'b1));

   a_r6_elem_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !last_o) |=> (elem_o == $past(elem_o) + 1'b1));
   a_r6_elem_restart: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (elem_o == '0));
endmodule

// File: rtl/vag_addr_path.sv
module vag_addr_path
   import vag_pkg::*;
#(
   parameter int AW         = 32,
   parameter int WORD_BYTES = 8,
   parameter int EW         = 6,
   parameter bit USE_MUL    = 1'b0,
   localparam int OB        = $clog2(WORD_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_i,
   input  vag_mode_e     mode_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] stride_i,
   input  logic [AW-1:0] idx_i,
   input  logic [EW-1:0] elem_i,
   output logic [AW-1:0] addr_o
);
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(WORD_BYTES - 1);

   vag_mode_e     mode_q;
   logic [AW-1:0] base_q;
   logic [AW-1:0] step_q;
   logic [AW-1:0] off;
   logic [AW-1:0] step_d;

   generate
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("vag_addr_path: WORD_BYTES must be a power of two");
      end
      if (AW <= OB) begin : g_bad_aw
         $error("vag_addr_path: AW too small for the word size");
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         VAG_UNIT:   step_d = AW'(WORD_BYTES);
         VAG_STRIDE: step_d = stride_i & ALIGN_MASK;
         VAG_IOTA:   step_d = stride_i;
         default:    step_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= VAG_UNIT;
         base_q <= '0;
         step_q <= '0;
      end else if (load_i) begin
         mode_q <= mode_i;
         base_q <= (mode_i == VAG_IOTA) ? '0 : (base_i & ALIGN_MASK);
         step_q <= step_d;
      end
   end

   generate
      if (USE_MUL) begin : g_mul
         assign off = AW'(elem_i) * step_q;
      end else begin : g_acc
         logic [AW-1:0] acc_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      acc_q <= '0;
            else if (load_i) acc_q <= '0;
            else if (step_i) acc_q <= acc_q + step_q;
         end
         assign off = acc_q;

         a_r6_acc_origin: assert property (@(posedge clk) disable iff (!rst_n)
            $past(load_i) |-> (elem_i == '0 && acc_q == '0));
      end
   endgenerate

   always_comb begin
      unique case (mode_q)
         VAG_INDEX: addr_o = base_q + (idx_i & ALIGN_MASK);
         VAG_IOTA:  addr_o = off;
         default:   addr_o = base_q + off;
      endcase
   end

   a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      is_addr_mode(mode_q) |-> (addr_o[OB-1:0] == '0));
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
   import vag_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LW         = 8,
   parameter int MAXVL      = 64,
   parameter int WORD_BYTES = 8,
   parameter bit USE_MUL    = 1'b0,
   localparam int CW        = $clog2(MAXVL + 1),
   localparam int EW        = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] stride_i,
   input  logic [LW-1:0] vlen_i,
   input  logic          idx_valid_i,
   input  logic [AW-1:0] idx_data_i,
   output logic          idx_ready_o,
   output logic          busy_o,
   output logic          out_valid_o,
   input  logic          out_ready_i,
   output logic [AW-1:0] out_addr_o,
   output logic [EW-1:0] out_elem_o,
   output logic          done_o
);
   vag_mode_e     mode_in;
   vag_mode_e     mode_q;
   logic [CW-1:0] eff_len;
   logic [CW-1:0] len_q;
   logic          busy_q;
   logic          done_q;
   logic          take;
   logic          hs;
   logic          last;

   assign mode_in = vag_mode_e'(mode_i);
   assign take    = start_i && !busy_q;

   vag_len_clamp #(.LW(LW), .MAXVL(MAXVL)) u_clamp (
      .req_i (vlen_i),
      .eff_o (eff_len)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= VAG_UNIT;
         len_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            mode_q <= mode_in;
            len_q  <= eff_len;
            if (eff_len == '0) done_q <= 1'b1;
            else               busy_q <= 1'b1;
         end else if (hs && last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   assign out_valid_o = busy_q && ((mode_q != VAG_INDEX) || idx_valid_i);
   assign idx_ready_o = busy_q && (mode_q == VAG_INDEX) && out_ready_i;
   assign hs          = out_valid_o && out_ready_i;
   assign busy_o      = busy_q;
   assign done_o      = done_q;

   vag_elem_ctr #(.MAXVL(MAXVL)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (take),
      .step_i (hs),
      .len_i  (len_q),
      .elem_o (out_elem_o),
      .last_o (last)
   );

   vag_addr_path #(
      .AW(AW), .WORD_BYTES(WORD_BYTES), .EW(EW), .USE_MUL(USE_MUL)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (take),
      .step_i   (hs),
      .mode_i   (mode_in),
      .base_i   (base_i),
      .stride_i (stride_i),
      .idx_i    (idx_data_i),
      .elem_i   (out_elem_o),
      .addr_o   (out_addr_o)
   );

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !out_valid_o));
   a_r7_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> ({1'b0, out_elem_o} < len_q));
   a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i && !start_i && $stable(idx_data_i)) |=>
         (out_elem_o == $past(out_elem_o)));
   a_r3_idx_only_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_ready_o && idx_valid_i) |-> (out_valid_o && out_ready_i));
   a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !(out_valid_o && out_ready_i)) |=>
         (busy_o && out_elem_o == $past(out_elem_o)));
   a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (take && eff_len == '0) |=> (done_o && !busy_o));
endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [AW-1:0] base_i = '0;
   logic [AW-1:0] stride_i = '0;
   logic [7:0]    vlen_i = '0;
   logic          idx_valid_i = 1'b0;
   logic [AW-1:0] idx_data_i = '0;
   logic          idx_ready_o;
   logic          busy_o;
   logic          out_valid_o;
   logic          out_ready_i = 1'b0;
   logic [AW-1:0] out_addr_o;
   logic [5:0]    out_elem_o;
   logic          done_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #10 clk = ~clk;

   vec_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .base_i(base_i), .stride_i(stride_i), .vlen_i(vlen_i),
      .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i),
      .idx_ready_o(idx_ready_o), .busy_o(busy_o), .out_valid_o(out_valid_o),
      .out_ready_i(out_ready_i), .out_addr_o(out_addr_o),
      .out_elem_o(out_elem_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] idx_of(input int e);
      return AW'(e * 24 + 16 + (e % 8));
   endfunction

   function automatic logic [AW-1:0] expect_addr(input logic [1:0] m, input logic [AW-1:0] b,
                                                 input logic [AW-1:0] s, input int e);
      logic [AW-1:0] bm = b & ~AW'(7);
      logic [AW-1:0] sm = s & ~AW'(7);
      case (m)
         2'd0:    return bm + AW'(8 * e);          // R1
         2'd1:    return bm + AW'(e) * sm;         // R2
         2'd2:    return bm + (idx_of(e) & ~AW'(7)); // R3
         default: return AW'(e) * s;               // R4
      endcase
   endfunction

   // fields: mode[82:81] base[80:49] stride[48:17] vlen[16:9] ready pattern[8:1] restart-while-busy[0]
   localparam int NT = 9;
   localparam logic [82:0] TBL [NT] = '{
      {2'd0, 32'h0000_1000, 32'h0,          8'd10,  8'hFF, 1'b0},
      {2'd0, 32'h0000_2005, 32'h0,          8'd7,   8'hA5, 1'b0},
      {2'd1, 32'h0000_4000, 32'h0000_0028,  8'd12,  8'h6D, 1'b0},
      {2'd1, 32'hFFFF_FF00, 32'h0000_010F,  8'd9,   8'hFF, 1'b1},
      {2'd2, 32'h0001_0003, 32'h0,          8'd11,  8'hB3, 1'b0},
      {2'd3, 32'h1234_5678, 32'h0000_0005,  8'd8,   8'h5F, 1'b0},
      {2'd3, 32'h0,         32'h0000_0040,  8'd64,  8'hFF, 1'b1},
      {2'd0, 32'h0000_8000, 32'h0,          8'd200, 8'hDB, 1'b0},
      {2'd2, 32'h0000_0100, 32'h0,          8'd1,   8'h3C, 1'b0}
   };

   task automatic run(input logic [1:0] m, input logic [AW-1:0] b, input logic [AW-1:0] s,
                      input logic [7:0] vl, input logic [7:0] pat, input logic restart);
      int e = 0;
      int expn = (vl > 8'd64) ? 64 : int'(vl);
      logic seen_done = 1'b0;
      @(posedge clk); #1;
      mode_i = m; base_i = b; stride_i = s; vlen_i = vl; start_i = 1'b1;
      idx_valid_i = 1'b0; idx_data_i = idx_of(0); out_ready_i = 1'b0;
      @(posedge clk); #1;
      start_i = 1'b0;
      for (int c = 0; c < 600 && !seen_done; c++) begin
         out_ready_i = pat[c % 8];
         idx_valid_i = (m != 2'd2) || (c >= 2);
         idx_data_i  = idx_of(e);
         if (restart && c == 3) begin
            start_i = 1'b1; base_i = b ^ 32'h0000_1000; vlen_i = 8'd3; mode_i = ~m;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         if (m == 2'd2 && c < 2) check("R3 no offer without index", AW'(out_valid_o), 0);
         if (out_valid_o) begin
            check("R6 element order", AW'(out_elem_o), AW'(e));
            check(m == 2'd0 ? "R1 unit address" : m == 2'd1 ? "R2 stride address" :
                  m == 2'd2 ? "R3 index address" : "R4 index value",
                  out_addr_o, expect_addr(m, b, s, e));
            if (m != 2'd3) check("R5 alignment", AW'(out_addr_o[2:0]), 0);
            if (m == 2'd2) check("R3 index consumed with handshake",
                                 AW'(idx_ready_o), AW'(out_ready_i));
            if (out_ready_i) e = e + 1;
         end
         if (done_o) begin
            seen_done = 1'b1;
            check(vl == 8'd0 ? "R8 zero length count" : vl > 8'd64 ? "R7 clamped count" :
                  restart ? "R10 start ignored count" : "R7 element count", AW'(e), AW'(expn));
            check("R9 busy low at done", AW'(busy_o), 0);
         end
         @(posedge clk); #1;
      end
      start_i = 1'b0;
      check("R9 done seen", AW'(seen_done), 1);
      @(negedge clk);
      check("R9 done is one cycle", AW'(done_o), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 busy after reset", AW'(busy_o), 0);
      check("R11 valid after reset", AW'(out_valid_o), 0);
      check("R11 done after reset", AW'(done_o), 0);
      check("R11 idx_ready after reset", AW'(idx_ready_o), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      for (int t = 0; t < NT; t++)
         run(TBL[t][82:81], TBL[t][80:49], TBL[t][48:17], TBL[t][16:9], TBL[t][8:1], TBL[t][0]);

      // R8: zero length, done in the cycle after the start is taken
      @(posedge clk); #1;
      mode_i = 2'd1; base_i = 32'h40; stride_i = 32'h8; vlen_i = 8'd0; start_i = 1'b1;
      out_ready_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      check("R8 done after zero-length start", AW'(done_o), 1);
      check("R8 no element offered", AW'(out_valid_o), 0);
      check("R8 not busy", AW'(busy_o), 0);
      @(negedge clk);
      check("R8 done one cycle only", AW'(done_o), 0);

      // R6: long stall holds address and element
      @(posedge clk); #1;
      mode_i = 2'd1; base_i = 32'h100; stride_i = 32'h18; vlen_i = 8'd3; start_i = 1'b1;
      out_ready_i = 1'b0;
      @(posedge clk); #1;
      start_i = 1'b0;
      repeat (5) @(negedge clk);
      check("R6 element held in stall", AW'(out_elem_o), 0);
      check("R6 address held in stall", out_addr_o, 32'h100);
      @(posedge clk); #1;
      out_ready_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R6 next element after stall", AW'(out_elem_o), 1);
      check("R2 address after stall", out_addr_o, 32'h118);
      repeat (4) @(negedge clk);
      check("R9 idle after stalled run", AW'(busy_o), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule